// File: doc/BRIEF.md
# Store Queue with Read-Miss Bypass

This block sits between a write-through data cache and a single memory port that is slower than the cache. Stores are captured into a small queue and written to memory in the background, so the processor does not wait for them. A read miss does not wait for the queue to empty. Its address is checked against every queued store. If there is no match, the read takes the memory port ahead of all queued stores. If there is a match, the newest matching store's data is returned directly and memory is not touched.

The read-miss side uses a one-cycle handshake: the request is accepted when `rd_valid_i` and `rd_ready_o` are both high. The answer comes back as a one-cycle `rd_done_o` pulse. A replaced dirty block can be offered as a store in the same cycle as the read miss that displaced it. That store counts as older than the read. It is visible to the read, and it reaches memory only after the read data has returned. On the memory side, a request is taken in any cycle in which `mem_req_o` and `mem_gnt_i` are both high. Read data arrives on `mem_rvalid_i` at least one cycle after the grant.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset the queue is empty (`count_o`=0, `full_o`=0), `mem_req_o` is low, `rd_ready_o` is high and `rd_done_o` is low.
- R2: A store is taken when `wr_valid_i` and `wr_ready_o` are both high. The queue holds at most 4 entries. At 4 entries `full_o`=1 and `wr_ready_o`=0, and a store offered while full is dropped and never reaches memory.
- R3: While no read miss is being served, queued stores are presented oldest first with `mem_we_o`=1 and that entry's address and data. Each `mem_gnt_i` removes exactly one entry.
- R4: A read miss whose address matches no queued entry and no same-cycle store drives a memory read (`mem_req_o`=1, `mem_we_o`=0, `mem_addr_o`=read address) in its acceptance cycle. From then until the read data returns, no store is presented.
- R5: One cycle after `mem_rvalid_i` is high for an outstanding read, `rd_done_o` pulses with `rd_data_o` equal to the returned word and `rd_fwd_o`=0.
- R6: A read whose address matches a queued entry issues no memory read. The next cycle `rd_done_o` pulses with `rd_fwd_o`=1 and the data of the newest matching entry.
- R7: A store accepted in the same cycle as a read miss is older than that read. It is matched by the read, and it is written to memory only after the read completes.
- R8: A store accepted in the same cycle that an entry drains leaves `count_o` unchanged.
- R9: A memory read that is not granted is presented again in the following cycle with the same address until it is granted.
- R10: `rd_ready_o` is low from the cycle after a read miss is accepted until the cycle after its data returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Store offered |
| wr_addr_i | input | AW | Store address |
| wr_data_i | input | DW | Store data |
| wr_ready_o | output | 1 | Queue can take a store |
| rd_valid_i | input | 1 | Read miss offered |
| rd_addr_i | input | AW | Read miss address |
| rd_ready_o | output | 1 | Read miss can be accepted |
| rd_done_o | output | 1 | Read answer pulse |
| rd_data_o | output | DW | Read answer data |
| rd_fwd_o | output | 1 | Answer came from the queue |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_gnt_i | input | 1 | Memory takes the request this cycle |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | DW | Memory read data |
| full_o | output | 1 | Queue holds 4 entries |
| count_o | output | CW | Number of queued entries |

## Verification
The bypass is tried in four ways. The first is a read to an address absent from a full queue, which tells overtaking apart from draining first. The second is a read to an address stored twice, which tells newest-match from oldest-match forwarding. The third is a read paired with a same-cycle store, once to a different address and once to the same one, which separates the replaced-block ordering from forwarding of the incoming store. Grants are withheld and then released, which shows that a pending read is held steady and that stores stay blocked until the read data returns. A long pseudo-random stretch over eight addresses then mixes stores, reads and grant gaps against a queue-based reference.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {RD_IDLE, RD_REQ, RD_WAIT} rd_state_e;
endpackage

// File: rtl/wb_fifo.sv
module wb_fifo #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [AW-1:0]    push_addr_i,
  input  logic [DW-1:0]    push_data_i,
  input  logic             pop_i,
  output logic [AW-1:0]    head_addr_o,
  output logic [DW-1:0]    head_data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             age_valid_o [DEPTH],
  output logic [AW-1:0]    age_addr_o  [DEPTH],
  output logic [DW-1:0]    age_data_o  [DEPTH]
);
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_q <= bump(tail_q);
      if (pop_i)  head_q <= bump(head_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[tail_q] <= push_addr_i;
      data_q[tail_q] <= push_data_i;
    end
  end

  // entries presented oldest first
  always_comb begin
    logic [PTR_W-1:0] slot;
    for (int i = 0; i < DEPTH; i++) begin
      slot = PTR_W'((int'(head_q) + i) % DEPTH);
      age_valid_o[i] = i < int'(cnt_q);
      age_addr_o[i]  = addr_q[slot];
      age_data_o[i]  = data_q[slot];
    end
  end

  assign head_addr_o = addr_q[head_q];
  assign head_data_o = data_q[head_q];
  assign count_o     = cnt_q;
  assign full_o      = cnt_q == CNT_W'(DEPTH);
  assign empty_o     = cnt_q == '0;

  assert_no_pop_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  assert_push_pop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> count_o == $past(count_o));
endmodule

// File: rtl/wb_match.sv
module wb_match #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          lookup_valid_i,
  input  logic [AW-1:0] lookup_addr_i,
  input  logic          age_valid_i [DEPTH],
  input  logic [AW-1:0] age_addr_i  [DEPTH],
  input  logic [DW-1:0] age_data_i  [DEPTH],
  input  logic          inc_valid_i,
  input  logic [AW-1:0] inc_addr_i,
  input  logic [DW-1:0] inc_data_i,
  output logic          hit_o,
  output logic [DW-1:0] hit_data_o
);
  // later (younger) matches override earlier ones; incoming store is youngest
  always_comb begin
    hit_o      = 1'b0;
    hit_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lookup_valid_i && age_valid_i[i] && age_addr_i[i] == lookup_addr_i) begin
        hit_o      = 1'b1;
        hit_data_o = age_data_i[i];
      end
    end
    if (lookup_valid_i && inc_valid_i && inc_addr_i == lookup_addr_i) begin
      hit_o      = 1'b1;
      hit_data_o = inc_data_i;
    end
  end
endmodule

// File: rtl/wb_port_arb.sv
module wb_port_arb
  import wb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_valid_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rd_ready_o,
  output logic          rd_done_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_fwd_o,
  input  logic          hit_i,
  input  logic [DW-1:0] hit_data_i,
  input  logic          empty_i,
  input  logic [AW-1:0] head_addr_i,
  input  logic [DW-1:0] head_data_i,
  output logic          pop_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i
);
  rd_state_e     state_q;
  logic [AW-1:0] raddr_q;
  logic [DW-1:0] rdata_q;
  logic          done_q, fwd_q;
  logic          rd_miss;

  assign rd_ready_o = state_q == RD_IDLE;
  assign rd_miss    = rd_ready_o && rd_valid_i && !hit_i;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = head_addr_i;
    mem_wdata_o = head_data_i;
    if (rd_miss) begin
      mem_req_o  = 1'b1;
      mem_addr_o = rd_addr_i;
    end else if (state_q == RD_REQ) begin
      mem_req_o  = 1'b1;
      mem_addr_o = raddr_q;
    end else if (state_q == RD_IDLE && !empty_i) begin
      mem_req_o = 1'b1;
      mem_we_o  = 1'b1;
    end
  end

  assign pop_o = mem_req_o && mem_we_o && mem_gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_IDLE;
      raddr_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      fwd_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        RD_IDLE: begin
          if (rd_valid_i && hit_i) begin
            done_q  <= 1'b1;
            rdata_q <= hit_data_i;
            fwd_q   <= 1'b1;
          end else if (rd_miss) begin
            raddr_q <= rd_addr_i;
            state_q <= mem_gnt_i ? RD_WAIT : RD_REQ;
          end
        end
        RD_REQ:  if (mem_gnt_i) state_q <= RD_WAIT;
        RD_WAIT: begin
          if (mem_rvalid_i) begin
            done_q  <= 1'b1;
            rdata_q <= mem_rdata_i;
            fwd_q   <= 1'b0;
            state_q <= RD_IDLE;
          end
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  assign rd_done_o = done_q;
  assign rd_data_o = rdata_q;
  assign rd_fwd_o  = fwd_q;

  assert_read_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && !mem_gnt_i)
      |=> (mem_req_o && !mem_we_o && mem_addr_o == $past(mem_addr_o)));
  assert_no_store_in_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != RD_IDLE) |-> !(mem_req_o && mem_we_o));
  assert_fwd_answer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_ready_o && hit_i) |=> (rd_done_o && rd_fwd_o && !$past(mem_req_o && !mem_we_o)));
  assert_mem_answer_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RD_WAIT && mem_rvalid_i)
      |=> (rd_done_o && !rd_fwd_o && rd_data_o == $past(mem_rdata_i)));
endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_ready_o,
  input  logic          rd_valid_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rd_ready_o,
  output logic          rd_done_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_fwd_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic          push, pop, empty, hit;
  logic [DW-1:0] hit_data;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;
  logic          age_valid [DEPTH];
  logic [AW-1:0] age_addr  [DEPTH];
  logic [DW-1:0] age_data  [DEPTH];

  assign wr_ready_o = !full_o;
  assign push       = wr_valid_i && wr_ready_o;

  wb_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .push_addr_i(wr_addr_i), .push_data_i(wr_data_i),
    .pop_i(pop),
    .head_addr_o(head_addr), .head_data_o(head_data),
    .count_o, .full_o, .empty_o(empty),
    .age_valid_o(age_valid), .age_addr_o(age_addr), .age_data_o(age_data)
  );

  wb_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_match (
    .lookup_valid_i(rd_valid_i), .lookup_addr_i(rd_addr_i),
    .age_valid_i(age_valid), .age_addr_i(age_addr), .age_data_i(age_data),
    .inc_valid_i(push), .inc_addr_i(wr_addr_i), .inc_data_i(wr_data_i),
    .hit_o(hit), .hit_data_o(hit_data)
  );

  wb_port_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk_i, .rst_ni,
    .rd_valid_i, .rd_addr_i, .rd_ready_o, .rd_done_o, .rd_data_o, .rd_fwd_o,
    .hit_i(hit), .hit_data_i(hit_data),
    .empty_i(empty), .head_addr_i(head_addr), .head_data_i(head_data),
    .pop_o(pop),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i
  );

  assert_full_stalls_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop) |=> (count_o == $past(count_o)));
  assert_ready_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_ready_o && !hit) |=> !rd_ready_o);
endmodule

// File: tb/sim_wbuf_bypass.sv
module sim_wbuf_bypass;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 0, rd_valid = 0, mem_gnt = 0, mem_rvalid = 0;
  logic [31:0] wr_addr = 0, wr_data = 0, rd_addr = 0, mem_rdata = 0;
  logic        wr_ready, rd_ready, rd_done, rd_fwd, mem_req, mem_we, full;
  logic [31:0] rd_data, mem_addr, mem_wdata;
  logic [2:0]  count;

  int compared = 0, mismatched = 0;
  bit reset_phase = 1'b0;

  // reference state
  logic [31:0] qa[$], qd[$];
  int          rst_m = 0;       // 0 idle, 1 read waiting for grant, 2 read waiting for data
  logic [31:0] raddr_m = 0, data_m = 0;
  bit          done_m = 0, fwd_m = 0;
  int          pend = 0;
  logic [31:0] pend_data = 0;
  logic [31:0] mem [logic [31:0]];

  always #10 clk = ~clk;

  wbuf_bypass u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .rd_valid_i(rd_valid), .rd_addr_i(rd_addr), .rd_ready_o(rd_ready),
    .rd_done_o(rd_done), .rd_data_o(rd_data), .rd_fwd_o(rd_fwd),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .full_o(full), .count_o(count)
  );

  function automatic logic [31:0] mem_read(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : (a * 3 + 32'h7);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit wv, input logic [31:0] wa, input logic [31:0] wd,
                      input bit rv, input logic [31:0] ra, input bit g);
    bit e_full, hit, e_req, e_we, push, pop, rvalid_now;
    logic [31:0] hd, e_addr, e_wd, rdata_now;
    string tq, tm;
    @(negedge clk);
    wr_valid = wv; wr_addr = wa; wr_data = wd;
    rd_valid = rv; rd_addr = ra; mem_gnt = g;
    rvalid_now = (pend == 1);
    rdata_now  = pend_data;
    mem_rvalid = rvalid_now;
    mem_rdata  = rdata_now;
    #1;
    e_full = qa.size() == 4;
    hit = 0; hd = 0;
    if (rst_m == 0 && rv) begin
      foreach (qa[i]) if (qa[i] == ra) begin hit = 1; hd = qd[i]; end
      if (wv && !e_full && wa == ra) begin hit = 1; hd = wd; end
    end
    e_req = 0; e_we = 0; e_addr = 0; e_wd = 0;
    if (rst_m == 0 && rv && !hit) begin e_req = 1; e_addr = ra; end
    else if (rst_m == 1) begin e_req = 1; e_addr = raddr_m; end
    else if (rst_m == 0 && qa.size() > 0) begin e_req = 1; e_we = 1; e_addr = qa[0]; e_wd = qd[0]; end
    push = wv && !e_full;
    pop  = e_req && e_we && g;

    tq = (push && pop) ? "R8" : "R2";
    if (rst_m == 1) tm = "R9";
    else if (rv && wv) tm = "R7";
    else if (e_req && !e_we) tm = "R4";
    else tm = "R3";
    if (reset_phase) begin tq = "R1"; tm = "R1"; end

    chk(tq, "count", 32'(count), 32'(qa.size()));
    chk(tq, "full", 32'(full), 32'(e_full));
    chk(tq, "wr_ready", 32'(wr_ready), 32'(!e_full));
    chk(reset_phase ? "R1" : "R10", "rd_ready", 32'(rd_ready), 32'(rst_m == 0));
    chk(tm, "mem_req", 32'(mem_req), 32'(e_req));
    if (e_req) begin
      chk(tm, "mem_we", 32'(mem_we), 32'(e_we));
      chk(tm, "mem_addr", mem_addr, e_addr);
      if (e_we) chk(tm, "mem_wdata", mem_wdata, e_wd);
    end
    chk(reset_phase ? "R1" : (fwd_m ? "R6" : "R5"), "rd_done", 32'(rd_done), 32'(done_m));
    if (done_m) begin
      chk(fwd_m ? "R6" : "R5", "rd_data", rd_data, data_m);
      chk(fwd_m ? "R6" : "R5", "rd_fwd", 32'(rd_fwd), 32'(fwd_m));
    end

    @(posedge clk);
    if (pop) begin void'(qa.pop_front()); void'(qd.pop_front()); end
    if (push) begin qa.push_back(wa); qd.push_back(wd); end
    if (pend > 0) pend--;
    if (e_req && g) begin
      if (e_we) mem[e_addr] = e_wd;
      else begin pend = 2; pend_data = mem_read(e_addr); end
    end
    done_m = 0;
    case (rst_m)
      0: if (rv) begin
           if (hit) begin done_m = 1; data_m = hd; fwd_m = 1; end
           else begin raddr_m = ra; rst_m = g ? 2 : 1; end
         end
      1: if (g) rst_m = 2;
      default: if (rvalid_now) begin rst_m = 0; done_m = 1; data_m = rdata_now; fwd_m = 0; end
    endcase
  endtask

  task automatic idle(input int n, input bit g);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, g);
  endtask

  initial begin
    #(20 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: state right after reset
    reset_phase = 1'b1;
    step(0, 0, 0, 0, 0, 0);
    reset_phase = 1'b0;

    // R2: fill to four, fifth store dropped while full
    step(1, 32'h10, 32'hA1, 0, 0, 0);
    step(1, 32'h20, 32'hA2, 0, 0, 0);
    step(1, 32'h30, 32'hA3, 0, 0, 0);
    step(1, 32'h40, 32'hA4, 0, 0, 0);
    step(1, 32'h50, 32'hBAD, 0, 0, 0);
    // R6: hit on queued entry
    step(0, 0, 0, 1, 32'h20, 0);
    idle(1, 0);
    // R4, R9, R10, R5: miss overtakes full queue, grant withheld twice
    step(0, 0, 0, 1, 32'h99, 0);
    idle(2, 0);
    idle(4, 1);
    // R3, R8: drain with simultaneous stores
    step(1, 32'h60, 32'hA6, 0, 0, 1);
    step(1, 32'h64, 32'hA7, 0, 0, 1);
    idle(6, 1);
    // R6: newest of two same-address stores wins
    step(1, 32'h80, 32'hB1, 0, 0, 0);
    step(1, 32'h80, 32'hB2, 0, 0, 0);
    step(0, 0, 0, 1, 32'h80, 0);
    idle(6, 1);
    // R7: replaced block written with a miss to another address
    step(1, 32'h70, 32'hC1, 1, 32'h74, 1);
    idle(5, 1);
    // R7: same-cycle store forwarded to the read
    step(1, 32'h90, 32'hC2, 1, 32'h90, 0);
    idle(6, 1);

    // pseudo-random mix over eight addresses
    for (int n = 0; n < 800; n++) begin
      automatic int r = $urandom;
      step(r[1:0] != 0, 32'(r[4:2]) << 2, 32'($urandom),
           r[7:5] == 0, 32'(r[10:8]) << 2, r[12:11] != 0);
    end
    idle(20, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule